// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer with Write-Protect Watch

This block sequences page writes inside a serial EEPROM that acts as an I2C target. A bus front end hands it already-decoded events: a write-transaction start carrying the target address, a strobe for every data bit captured on a rising SCL edge, a strobe for every completed data byte, and a STOP strobe. Data bytes collect in a page buffer. When a STOP lands on a byte boundary, the buffered bytes are committed to the memory array. A timed internal programming cycle follows, and a busy flag is held for its whole length so the front end can refuse to acknowledge its address (acknowledge polling).

The write-protect pin is synchronised and qualified: it only counts once it has stayed high for one microsecond's worth of system clocks. It is watched from the first data bit of the first byte until the programming cycle ends. If it is seen qualified before the STOP, the write is dropped and the array is not touched. If it is seen qualified while the block is committing or programming, work stops at once and a sticky corrupt flag is raised. The next write that completes normally clears that flag. Every time limit derives from `CLK_PER_US` (system clocks per microsecond) and `TWR_US` (programming-cycle length in microseconds), so the limits can be scaled down for simulation.

States: `ST_IDLE`, `ST_ARMED` (write addressed, window not yet open), `ST_WATCH` (window open, bytes collecting), `ST_COMMIT` (one buffer slot per cycle written to the array), `ST_PROG` (rest of the programming time). Transitions:
- start: `ST_IDLE` to `ST_ARMED`.
- open: first data bit, `ST_ARMED` to `ST_WATCH`.
- early-stop: `ST_ARMED` to `ST_IDLE`.
- cancel: WP qualified in the window, `ST_ARMED` or `ST_WATCH` to `ST_IDLE`.
- misaligned-stop: `ST_WATCH` to `ST_IDLE`.
- launch: aligned STOP, `ST_WATCH` to `ST_COMMIT`.
- drain: last slot, `ST_COMMIT` to `ST_PROG`.
- abort: WP qualified, `ST_COMMIT` or `ST_PROG` to `ST_IDLE`.
- finish: timer done, `ST_PROG` to `ST_IDLE`.

Top module: `wpc_write_ctrl`

## Requirements
- R1: After reset, busy, corrupt and mem_we are all low.
- R2: A STOP after N whole bytes (1 to 8) starting at address A writes each byte to A's page at offset (A mod 8 plus its index) mod 8, with at most one write per cycle. busy is high from the cycle after the STOP for exactly CLK_PER_US*TWR_US cycles (48 by default).
- R3: Bytes past the end of the 8-byte page wrap to the page start, and when a slot is written twice the later byte is the one stored.
- R4: A STOP whose bit count since the first data bit is not a multiple of 8, or that arrives before any data bit, causes no array write and no busy period.
- R5: A qualified WP seen while the window is open before the STOP (including at the first data bit) cancels the write: no array write, busy stays low, corrupt unchanged.
- R6: A WP high pulse shorter than CLK_PER_US cycles (one microsecond) is ignored and the write proceeds normally.
- R7: WP activity that ends before the first data bit of the first byte has no effect on the write.
- R8: A qualified WP while busy ends the cycle at once: busy falls the cycle after it is seen, no further array write is issued, and corrupt goes high.
- R9: corrupt stays high until a later programming cycle runs to completion, then falls at the end of that cycle.
- R10: A write start pulse, data bits and STOP presented while busy is high are ignored, with no extra array writes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Write transaction addressed (one-cycle pulse) |
| wr_addr | input | ADDR_W | Start word address for the write |
| bit_rise | input | 1 | Data bit captured on a rising SCL edge |
| byte_stb | input | 1 | Data byte complete; pulses with the eighth bit_rise |
| byte_data | input | 8 | Completed data byte |
| stop_evt | input | 1 | STOP condition seen |
| wp_pin | input | 1 | Asynchronous write-protect pin |
| busy | output | 1 | Commit or programming cycle in progress |
| corrupt | output | 1 | Sticky: last programming cycle was aborted |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A STOP sampled on an edge moves the state to `ST_COMMIT` on that edge, so busy is first seen high at the next falling edge. From there it is counted on every falling edge until it drops, and the count must equal 48. A raw WP change passes two synchroniser stages and then needs CLK_PER_US consecutive high samples. Cancel and abort stimuli therefore hold WP for 8 cycles, and the ignored pulse lasts only 2. Array writes are captured at the rising edge on which they take effect, and each scenario compares the number of writes and the page contents only after busy has fallen.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WATCH,
        ST_COMMIT,
        ST_PROG
    } wsq_state_t;
endpackage

// File: rtl/wpc_wp_qual.sv
module wpc_wp_qual #(
    parameter int QUAL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_pin,
    output logic wp_act
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // two-stage synchroniser for the asynchronous pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= wp_pin;
            s2 <= s1;
        end
    end

    // count consecutive high samples, saturate at the qualifying length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!s2) begin
            cnt <= '0;
        end else if (cnt != CW'(QUAL_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wp_act = (cnt == CW'(QUAL_CYC));
endmodule

// File: rtl/wpc_prog_timer.sv
module wpc_prog_timer #(
    parameter int CLK_PER_US = 4,
    parameter int TWR_US     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int US_W  = (TWR_US > 1) ? $clog2(TWR_US) : 1;

    logic [DIV_W-1:0] div_q;
    logic [US_W-1:0]  us_q;
    logic             tick;

    assign tick = (div_q == DIV_W'(CLK_PER_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            us_q  <= '0;
        end else if (!run) begin
            div_q <= '0;
            us_q  <= '0;
        end else if (tick) begin
            div_q <= '0;
            us_q  <= us_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign done = run && tick && (us_q == US_W'(TWR_US - 1));
endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);
    localparam int SLOTS = 1 << OFF_W;

    logic [7:0]       slot_q [SLOTS];
    logic [SLOTS-1:0] vld_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else if (clear) begin
                vld_q[g]  <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(g)) begin
                slot_q[g] <= wr_data;
                vld_q[g]  <= 1'b1;
            end
        end
    end

    assign rd_data  = slot_q[rd_off];
    assign rd_valid = vld_q[rd_off];
endmodule

// File: rtl/wpc_write_ctrl.sv
module wpc_write_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int CLK_PER_US = 4,
    parameter int TWR_US     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              bit_rise,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              stop_evt,
    input  logic              wp_pin,
    output logic              busy,
    output logic              corrupt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    import wpc_pkg::*;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;

    wsq_state_t        state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [OFF_W-1:0]  cidx_q;
    logic [2:0]        bitc_q;
    logic              have_q;
    logic              wp_act;
    logic              tmr_done;
    logic              buf_clear;
    logic              buf_wr;
    logic [7:0]        buf_rd;
    logic              buf_vld;
    logic              in_busy;

    wpc_wp_qual #(.QUAL_CYC(CLK_PER_US)) u_wpq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wp_pin (wp_pin),
        .wp_act (wp_act)
    );

    wpc_prog_timer #(.CLK_PER_US(CLK_PER_US), .TWR_US(TWR_US)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_busy),
        .done  (tmr_done)
    );

    wpc_page_buf #(.OFF_W(OFF_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .wr_en    (buf_wr),
        .wr_off   (ptr_q),
        .wr_data  (byte_data),
        .rd_off   (cidx_q),
        .rd_data  (buf_rd),
        .rd_valid (buf_vld)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_evt)                state_d = ST_IDLE;
                else if (bit_rise && wp_act) state_d = ST_IDLE;
                else if (bit_rise)           state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (wp_act)        state_d = ST_IDLE;
                else if (stop_evt) state_d = (bitc_q == 3'd0 && have_q) ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (wp_act)                               state_d = ST_IDLE;
                else if (cidx_q == OFF_W'(PAGE_BYTES - 1)) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (wp_act || tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_busy   = (state_q == ST_COMMIT) || (state_q == ST_PROG);
        busy      = in_busy;
        buf_clear = (state_q == ST_IDLE) && wr_start;
        buf_wr    = (state_q == ST_WATCH) && byte_stb && !wp_act;
        mem_we    = (state_q == ST_COMMIT) && buf_vld && !wp_act;
        mem_addr  = {base_q, cidx_q};
        mem_wdata = buf_rd;
    end

    // transaction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
            bitc_q <= '0;
            have_q <= 1'b0;
        end else if (buf_clear) begin
            base_q <= wr_addr[ADDR_W-1:OFF_W];
            ptr_q  <= wr_addr[OFF_W-1:0];
            bitc_q <= '0;
            have_q <= 1'b0;
        end else if (state_q == ST_ARMED || state_q == ST_WATCH) begin
            if (bit_rise) bitc_q <= bitc_q + 1'b1;
            if (buf_wr) begin
                ptr_q  <= ptr_q + 1'b1;
                have_q <= 1'b1;
            end
        end
    end

    // commit slot index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cidx_q <= '0;
        else if (state_q != ST_COMMIT) cidx_q <= '0;
        else                          cidx_q <= cidx_q + 1'b1;
    end

    // sticky corrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   corrupt <= 1'b0;
        else if (in_busy && wp_act)                   corrupt <= 1'b1;
        else if (state_q == ST_PROG && tmr_done)      corrupt <= 1'b0;
    end
endmodule

// File: rtl/wpc_write_ctrl_chk.sv
module wpc_write_ctrl_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               corrupt,
    input logic               wp_act,
    input wpc_pkg::wsq_state_t state_q
);
    import wpc_pkg::*;

    AST_BUSY_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state_q) == ST_WATCH); // R4

    AST_CANCEL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && wp_act) |=> (state_q == ST_IDLE && !busy)); // R5

    AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wp_act) |=> (!busy && corrupt)); // R8

    AST_CORRUPT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(corrupt) |-> $past(state_q) == ST_PROG); // R9

    AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> state_q != ST_ARMED); // R10
endmodule

bind wpc_write_ctrl wpc_write_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .corrupt (corrupt),
    .wp_act  (wp_act),
    .state_q (state_q)
);

// File: tb/sim_wpc_write_ctrl.sv
`timescale 1ns/1ps
module sim_wpc_write_ctrl;
    localparam int TWR_CYC = 4 * 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic [7:0] wr_addr = '0;
    logic       bit_rise = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_evt = 1'b0;
    logic       wp_pin = 1'b0;
    logic       busy, corrupt, mem_we;
    logic [7:0] mem_addr, mem_wdata;

    int  total = 0;
    int  bad = 0;
    int  wr_total = 0;
    bit  finished = 1'b0;
    logic [7:0] act_mem [256];
    logic [7:0] exp_mem [256];

    always #2.5 clk = ~clk;

    wpc_write_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .bit_rise(bit_rise), .byte_stb(byte_stb), .byte_data(byte_data),
        .stop_evt(stop_evt), .wp_pin(wp_pin), .busy(busy), .corrupt(corrupt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            act_mem[mem_addr] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_wr(input logic [7:0] a);
        @(negedge clk); wr_start = 1'b1; wr_addr = a;
        @(negedge clk); wr_start = 1'b0;
    endtask

    task automatic send_bits(input int nbits, input logic [7:0] b);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_rise = 1'b1;
            if (i == 7) begin byte_stb = 1'b1; byte_data = b; end
            @(negedge clk);
            bit_rise = 1'b0; byte_stb = 1'b0;
        end
    endtask

    task automatic send_stop;
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    // called at the first falling edge after STOP; counts busy samples
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic wp_pulse(input int cyc);
        @(negedge clk); wp_pin = 1'b1;
        idle(cyc);
        wp_pin = 1'b0;
    endtask

    function automatic void model_page(input logic [7:0] a, input int nb, input logic [7:0] seed);
        for (int k = 0; k < nb; k++)
            exp_mem[{a[7:3], 3'(a[2:0] + 3'(k))}] = seed + 8'(k);
    endfunction

    function automatic int page_diff(input logic [7:0] a);
        int d = 0;
        for (int k = 0; k < 8; k++)
            if (act_mem[{a[7:3], 3'(k)}] !== exp_mem[{a[7:3], 3'(k)}]) d++;
        return d;
    endfunction

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 corrupt", corrupt, 0);
        chk("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_basic;
        int n, w0;
        w0 = wr_total;
        start_wr(8'h40);
        for (int k = 0; k < 3; k++) send_bits(8, 8'h10 + 8'(k));
        send_stop;
        count_busy(n);
        chk("R2 busy length", n, TWR_CYC);
        idle(2);
        model_page(8'h40, 3, 8'h10);
        chk("R2 write count", wr_total - w0, 3);
        chk("R2 page data", page_diff(8'h40), 0);
    endtask

    task automatic t_wrap;
        int n, w0;
        w0 = wr_total;
        start_wr(8'h1E);
        for (int k = 0; k < 10; k++) send_bits(8, 8'hA0 + 8'(k));
        send_stop;
        count_busy(n);
        idle(2);
        model_page(8'h1E, 10, 8'hA0);
        chk("R3 write count", wr_total - w0, 8);
        chk("R3 wrapped page data", page_diff(8'h1E), 0);
        chk("R3 slot rewritten", act_mem[8'h1E], 8'hA8);
    endtask

    task automatic t_misaligned;
        int w0;
        w0 = wr_total;
        start_wr(8'h50);
        send_bits(8, 8'h33);
        send_bits(3, 8'h00);
        send_stop;
        idle(1);
        chk("R4 partial byte no busy", busy, 0);
        idle(4);
        start_wr(8'h58);
        send_stop;
        idle(1);
        chk("R4 no data no busy", busy, 0);
        idle(4);
        chk("R4 no writes", wr_total - w0, 0);
    endtask

    task automatic t_cancel;
        int w0;
        w0 = wr_total;
        start_wr(8'h60);
        send_bits(8, 8'h77);
        wp_pulse(8);
        idle(4);
        send_bits(8, 8'h78);
        send_stop;
        idle(1);
        chk("R5 cancel no busy", busy, 0);
        idle(4);
        chk("R5 cancel no writes", wr_total - w0, 0);
        chk("R5 corrupt unchanged", corrupt, 0);
        // WP already qualified when the first data bit arrives
        w0 = wr_total;
        start_wr(8'h68);
        @(negedge clk); wp_pin = 1'b1;
        idle(8);
        send_bits(8, 8'h79);
        wp_pin = 1'b0;
        idle(4);
        send_stop;
        idle(1);
        chk("R5 cancel at first bit no busy", busy, 0);
        idle(2);
        chk("R5 cancel at first bit no writes", wr_total - w0, 0);
    endtask

    task automatic t_short_pulse;
        int n, w0;
        w0 = wr_total;
        start_wr(8'h70);
        send_bits(8, 8'h21);
        wp_pulse(2);
        idle(4);
        send_bits(8, 8'h22);
        send_stop;
        count_busy(n);
        chk("R6 short pulse busy length", n, TWR_CYC);
        idle(2);
        model_page(8'h70, 2, 8'h21);
        chk("R6 short pulse writes", wr_total - w0, 2);
        chk("R6 page data", page_diff(8'h70), 0);
    endtask

    task automatic t_pre_window;
        int n, w0;
        w0 = wr_total;
        start_wr(8'hB0);
        wp_pulse(8);
        idle(6);
        send_bits(8, 8'h5A);
        send_stop;
        count_busy(n);
        chk("R7 pre-window busy length", n, TWR_CYC);
        idle(2);
        model_page(8'hB0, 1, 8'h5A);
        chk("R7 pre-window write", wr_total - w0, 1);
    endtask

    task automatic t_abort;
        int n;
        start_wr(8'h80);
        send_bits(8, 8'h01);
        send_bits(8, 8'h02);
        send_stop;
        idle(15);
        @(negedge clk); wp_pin = 1'b1;
        n = 17;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R8 abort ends early", (n < TWR_CYC) ? 1 : 0, 1);
        chk("R8 busy low after abort", busy, 0);
        chk("R8 corrupt set", corrupt, 1);
        idle(6);
        wp_pin = 1'b0;
        idle(6);
        model_page(8'h80, 2, 8'h01);
    endtask

    task automatic t_recover;
        int n;
        chk("R9 corrupt held while idle", corrupt, 1);
        start_wr(8'h90);
        send_bits(8, 8'h44);
        send_stop;
        idle(5);
        chk("R9 corrupt held mid-cycle", corrupt, 1);
        count_busy(n);
        chk("R9 corrupt cleared", corrupt, 0);
        model_page(8'h90, 1, 8'h44);
    endtask

    task automatic t_busy_ignore;
        int n, w0;
        w0 = wr_total;
        start_wr(8'hD0);
        send_bits(8, 8'h66);
        send_stop;
        idle(10);
        start_wr(8'hC0);
        send_bits(8, 8'h55);
        send_stop;
        count_busy(n);
        idle(10);
        chk("R10 busy stays low", busy, 0);
        chk("R10 no extra writes", wr_total - w0, 1);
        chk("R10 ignored target untouched", act_mem[8'hC0], 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin act_mem[i] = '0; exp_mem[i] = '0; end
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_basic;
        t_wrap;
        t_misaligned;
        t_cancel;
        t_short_pulse;
        t_pre_window;
        t_abort;
        t_recover;
        t_busy_ignore;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule